// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor that runs each instruction over several clock cycles on one shared datapath. A state register steps through a fixed set of ten steps. Every instruction starts with the same two steps: fetch, then decode and register read. After that the held instruction opcode selects the path for one of five instruction classes: memory load, memory store, register-to-register ALU operation, branch-on-equal and jump. When a class finishes its last step, the unit goes back to fetch.

The sixteen datapath control lines are a pure function of the current step. The opcode only affects which step comes next. The current step code is also driven on an output so that a datapath or a debug path can follow the sequence. The next step is produced one bit at a time, each bit being an OR of (step, opcode class) terms. A parameter can replace this with a plain case decode. A second parameter chooses how the control lines are decoded.

Top module: `mcyc_ctrl_fsm`

## Requirements
- R1: While rst_n is low (asynchronous, active low) cur_state is 0 and the outputs carry the step-0 control word of R10.
- R2: Step 0 is always followed by step 1, whatever the opcode.
- R3: In step 1 the opcode selects the next step. Load 100011 and store 101011 go to 2, register-format 000000 goes to 6, branch-equal 000100 goes to 8, jump 000010 goes to 9. Any other opcode goes to 0.
- R4: In step 2 a load opcode leads to 3 and a store opcode leads to 5. Any other opcode leads to 0.
- R5: Step 3 leads to 4 and step 6 leads to 7. Steps 4, 5, 7, 8 and 9 lead to 0. An instruction counted from fetch back to fetch therefore takes load 5, store 4, register-format 4, branch 3, jump 3 and unknown opcode 2 cycles.
- R6: The control outputs depend only on the current step. Changing the opcode between clock edges leaves every control output unchanged.
- R7: pc_wr is 1 only in steps 0 and 9. pc_wr_cond is 1 only in step 8.
- R8: rf_wr is 1 only in steps 4 and 7. rf_wb_sel is 1 only in step 4 (memory data). rf_dst_sel is 1 only in step 7.
- R9: mem_rd is 1 in steps 0 and 3. mem_wr is 1 only in step 5. mem_addr_sel is 1 in steps 3 and 5. mem_rd and mem_wr are never both 1.
- R10: Every output not listed for a step below is 0. Step 0: pc_wr, mem_rd, ir_wr, alu_b_sel=01. Step 1: alu_b_sel=11. Step 2: alu_a_sel, alu_b_sel=10. Step 3: mem_rd, mem_addr_sel. Step 4: rf_wr, rf_wb_sel. Step 5: mem_wr, mem_addr_sel. Step 6: alu_a_sel, alu_op=10. Step 7: rf_wr, rf_dst_sel. Step 8: alu_a_sel, alu_op=01, pc_wr_cond, pc_src_sel=01. Step 9: pc_wr, pc_src_sel=10.
- R11: cur_state never holds a code above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OP_W (6) | Opcode field of the held instruction |
| cur_state | output | STATE_W (4) | Current step code |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write gated by ALU zero |
| mem_addr_sel | output | 1 | Memory address: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_wr | output | 1 | Instruction register load |
| rf_wb_sel | output | 1 | Register write data: 0 ALU result, 1 memory data |
| pc_src_sel | output | 2 | Next PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_b_sel | output | 2 | ALU B input: 00 register, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_a_sel | output | 1 | ALU A input: 0 program counter, 1 register |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |

## Verification
The properties assume that the opcode seen at a clock edge is the value the block decodes. They do not require it to stay constant across an instruction, because the dispatch checks re-read it at every edge. They also assume that the five class opcodes are distinct, which the top enforces at elaboration. The bench changes the opcode only between clock edges. It moves the opcode away from its value in the middle of a cycle to show that the outputs do not follow it, and restores it before the next edge. The one deliberate change of class in step 2 is also applied between edges.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;

   localparam int NUM_STATES = 10;
   localparam int CTRL_W     = 16;

   localparam int ST_FETCH = 0;
   localparam int ST_DECODE = 1;
   localparam int ST_ADDR  = 2;
   localparam int ST_MRD   = 3;
   localparam int ST_LDWB  = 4;
   localparam int ST_MWR   = 5;
   localparam int ST_EXEC  = 6;
   localparam int ST_ALUWB = 7;
   localparam int ST_BEQ   = 8;
   localparam int ST_JMP   = 9;

   typedef struct packed {
      logic       pc_wr;
      logic       pc_wr_cond;
      logic       mem_addr_sel;
      logic       mem_rd;
      logic       mem_wr;
      logic       ir_wr;
      logic       rf_wb_sel;
      logic [1:0] pc_src_sel;
      logic [1:0] alu_op;
      logic [1:0] alu_b_sel;
      logic       alu_a_sel;
      logic       rf_wr;
      logic       rf_dst_sel;
   } ctrl_t;

   typedef struct packed {
      logic ld;
      logic st;
      logic rr;
      logic beq;
      logic jmp;
   } op_cls_t;

   // Control word asserted in one step; everything else stays low.
   function automatic ctrl_t ctrl_of(input int s);
      ctrl_t c;
      c = '0;
      case (s)
         ST_FETCH: begin
            c.pc_wr = 1'b1; c.mem_rd = 1'b1; c.ir_wr = 1'b1; c.alu_b_sel = 2'b01;
         end
         ST_DECODE: c.alu_b_sel = 2'b11;
         ST_ADDR: begin
            c.alu_a_sel = 1'b1; c.alu_b_sel = 2'b10;
         end
         ST_MRD: begin
            c.mem_rd = 1'b1; c.mem_addr_sel = 1'b1;
         end
         ST_LDWB: begin
            c.rf_wr = 1'b1; c.rf_wb_sel = 1'b1;
         end
         ST_MWR: begin
            c.mem_wr = 1'b1; c.mem_addr_sel = 1'b1;
         end
         ST_EXEC: begin
            c.alu_a_sel = 1'b1; c.alu_op = 2'b10;
         end
         ST_ALUWB: begin
            c.rf_wr = 1'b1; c.rf_dst_sel = 1'b1;
         end
         ST_BEQ: begin
            c.alu_a_sel = 1'b1; c.alu_op = 2'b01; c.pc_wr_cond = 1'b1; c.pc_src_sel = 2'b01;
         end
         ST_JMP: begin
            c.pc_wr = 1'b1; c.pc_src_sel = 2'b10;
         end
         default: c = '0;
      endcase
      return c;
   endfunction

   // Set of steps whose code has bit b set.
   function automatic logic [NUM_STATES-1:0] code_bit_mask(input int b);
      logic [NUM_STATES-1:0] m;
      m = '0;
      for (int k = 0; k < NUM_STATES; k++) m[k] = ((k >> b) & 1) == 1;
      return m;
   endfunction

   // Set of steps in which control bit b is asserted.
   function automatic logic [NUM_STATES-1:0] ctrl_bit_mask(input int b);
      logic [NUM_STATES-1:0] m;
      logic [CTRL_W-1:0]     w;
      m = '0;
      for (int k = 0; k < NUM_STATES; k++) begin
         w    = ctrl_of(k);
         m[k] = w[b];
      end
      return m;
   endfunction

endpackage

// File: rtl/mcyc_op_class.sv
module mcyc_op_class
   import mcyc_ctrl_pkg::*;
#(
   parameter int              OP_W    = 6,
   parameter logic [OP_W-1:0] OP_LOAD = OP_W'(6'b100011),
   parameter logic [OP_W-1:0] OP_STORE = OP_W'(6'b101011),
   parameter logic [OP_W-1:0] OP_RREG = OP_W'(6'b000000),
   parameter logic [OP_W-1:0] OP_BEQ  = OP_W'(6'b000100),
   parameter logic [OP_W-1:0] OP_JUMP = OP_W'(6'b000010)
) (
   input  logic [OP_W-1:0] opcode,
   output op_cls_t         cls
);
   always_comb begin
      cls.ld  = (opcode == OP_LOAD);
      cls.st  = (opcode == OP_STORE);
      cls.rr  = (opcode == OP_RREG);
      cls.beq = (opcode == OP_BEQ);
      cls.jmp = (opcode == OP_JUMP);
   end
endmodule

// File: rtl/mcyc_next_state.sv
module mcyc_next_state
   import mcyc_ctrl_pkg::*;
#(
   parameter int STATE_W  = 4,
   parameter int NS_STYLE = 0   // 0: per-bit OR of terms, 1: case decode
) (
   input  logic [STATE_W-1:0] state,
   input  op_cls_t            cls,
   output logic [STATE_W-1:0] nxt
);
   generate
      if (NS_STYLE == 0) begin : g_sop
         logic [NUM_STATES-1:0] hit;
         logic [NUM_STATES-1:0] tgt;

         for (genvar k = 0; k < NUM_STATES; k++) begin : g_hit
            assign hit[k] = (state == STATE_W'(k));
         end

         // tgt[k] is high when step k is the next step; step 0 is the fallback.
         assign tgt[ST_FETCH]  = 1'b0;
         assign tgt[ST_DECODE] = hit[ST_FETCH];
         assign tgt[ST_ADDR]   = hit[ST_DECODE] & (cls.ld | cls.st);
         assign tgt[ST_MRD]    = hit[ST_ADDR] & cls.ld;
         assign tgt[ST_LDWB]   = hit[ST_MRD];
         assign tgt[ST_MWR]    = hit[ST_ADDR] & cls.st;
         assign tgt[ST_EXEC]   = hit[ST_DECODE] & cls.rr;
         assign tgt[ST_ALUWB]  = hit[ST_EXEC];
         assign tgt[ST_BEQ]    = hit[ST_DECODE] & cls.beq;
         assign tgt[ST_JMP]    = hit[ST_DECODE] & cls.jmp;

         for (genvar j = 0; j < STATE_W; j++) begin : g_bit
            localparam logic [NUM_STATES-1:0] TERMS = code_bit_mask(j);
            assign nxt[j] = |(tgt & TERMS);
         end
      end else begin : g_case
         always_comb begin
            nxt = STATE_W'(ST_FETCH);
            case (int'(state))
               ST_FETCH:  nxt = STATE_W'(ST_DECODE);
               ST_DECODE: begin
                  if (cls.ld || cls.st) nxt = STATE_W'(ST_ADDR);
                  else if (cls.rr)      nxt = STATE_W'(ST_EXEC);
                  else if (cls.beq)     nxt = STATE_W'(ST_BEQ);
                  else if (cls.jmp)     nxt = STATE_W'(ST_JMP);
               end
               ST_ADDR: begin
                  if (cls.ld)      nxt = STATE_W'(ST_MRD);
                  else if (cls.st) nxt = STATE_W'(ST_MWR);
               end
               ST_MRD:  nxt = STATE_W'(ST_LDWB);
               ST_EXEC: nxt = STATE_W'(ST_ALUWB);
               default: nxt = STATE_W'(ST_FETCH);
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/mcyc_out_decode.sv
module mcyc_out_decode
   import mcyc_ctrl_pkg::*;
#(
   parameter int STATE_W   = 4,
   parameter int OUT_STYLE = 0   // 0: per-signal OR of step terms, 1: table lookup
) (
   input  logic [STATE_W-1:0] state,
   output ctrl_t              ctrl
);
   generate
      if (OUT_STYLE == 0) begin : g_sop
         logic [NUM_STATES-1:0] hit;
         logic [CTRL_W-1:0]     bits;

         for (genvar k = 0; k < NUM_STATES; k++) begin : g_hit
            assign hit[k] = (state == STATE_W'(k));
         end
         for (genvar b = 0; b < CTRL_W; b++) begin : g_sig
            localparam logic [NUM_STATES-1:0] ON = ctrl_bit_mask(b);
            assign bits[b] = |(hit & ON);
         end
         assign ctrl = ctrl_t'(bits);
      end else begin : g_tab
         always_comb ctrl = ctrl_of(int'(state));
      end
   endgenerate
endmodule

// File: rtl/mcyc_ctrl_fsm.sv
module mcyc_ctrl_fsm
   import mcyc_ctrl_pkg::*;
#(
   parameter int              STATE_W   = 4,
   parameter int              OP_W      = 6,
   parameter int              NS_STYLE  = 0,
   parameter int              OUT_STYLE = 0,
   parameter logic [OP_W-1:0] OP_LOAD   = OP_W'(6'b100011),
   parameter logic [OP_W-1:0] OP_STORE  = OP_W'(6'b101011),
   parameter logic [OP_W-1:0] OP_RREG   = OP_W'(6'b000000),
   parameter logic [OP_W-1:0] OP_BEQ    = OP_W'(6'b000100),
   parameter logic [OP_W-1:0] OP_JUMP   = OP_W'(6'b000010)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OP_W-1:0]    opcode,
   output logic [STATE_W-1:0] cur_state,
   output logic               pc_wr,
   output logic               pc_wr_cond,
   output logic               mem_addr_sel,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic               ir_wr,
   output logic               rf_wb_sel,
   output logic [1:0]         pc_src_sel,
   output logic [1:0]         alu_op,
   output logic [1:0]         alu_b_sel,
   output logic               alu_a_sel,
   output logic               rf_wr,
   output logic               rf_dst_sel
);
   localparam int MIN_STATE_W = $clog2(NUM_STATES);

   generate
      if (STATE_W < MIN_STATE_W) begin : g_bad_sw
         $error("STATE_W too narrow for the step codes");
      end
      if (OP_W < 1) begin : g_bad_ow
         $error("OP_W must be at least 1");
      end
      if (NS_STYLE != 0 && NS_STYLE != 1) begin : g_bad_ns
         $error("NS_STYLE must be 0 or 1");
      end
      if (OUT_STYLE != 0 && OUT_STYLE != 1) begin : g_bad_os
         $error("OUT_STYLE must be 0 or 1");
      end
      if (OP_LOAD == OP_STORE || OP_LOAD == OP_RREG || OP_LOAD == OP_BEQ ||
          OP_LOAD == OP_JUMP  || OP_STORE == OP_RREG || OP_STORE == OP_BEQ ||
          OP_STORE == OP_JUMP || OP_RREG == OP_BEQ || OP_RREG == OP_JUMP ||
          OP_BEQ == OP_JUMP) begin : g_bad_op
         $error("class opcodes must be distinct");
      end
   endgenerate

   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] state_d;
   op_cls_t            cls;
   ctrl_t              ctrl;

   mcyc_op_class #(
      .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
      .OP_RREG(OP_RREG), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
   ) u_cls (
      .opcode(opcode),
      .cls   (cls)
   );

   mcyc_next_state #(.STATE_W(STATE_W), .NS_STYLE(NS_STYLE)) u_ns (
      .state(state_q),
      .cls  (cls),
      .nxt  (state_d)
   );

   mcyc_out_decode #(.STATE_W(STATE_W), .OUT_STYLE(OUT_STYLE)) u_dec (
      .state(state_q),
      .ctrl (ctrl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= STATE_W'(ST_FETCH);
      else        state_q <= state_d;
   end

   assign cur_state    = state_q;
   assign pc_wr        = ctrl.pc_wr;
   assign pc_wr_cond   = ctrl.pc_wr_cond;
   assign mem_addr_sel = ctrl.mem_addr_sel;
   assign mem_rd       = ctrl.mem_rd;
   assign mem_wr       = ctrl.mem_wr;
   assign ir_wr        = ctrl.ir_wr;
   assign rf_wb_sel    = ctrl.rf_wb_sel;
   assign pc_src_sel   = ctrl.pc_src_sel;
   assign alu_op       = ctrl.alu_op;
   assign alu_b_sel    = ctrl.alu_b_sel;
   assign alu_a_sel    = ctrl.alu_a_sel;
   assign rf_wr        = ctrl.rf_wr;
   assign rf_dst_sel   = ctrl.rf_dst_sel;
endmodule

// File: rtl/mcyc_ctrl_fsm_chk.sv
module mcyc_ctrl_fsm_chk #(
   parameter int              STATE_W  = 4,
   parameter int              OP_W     = 6,
   parameter logic [OP_W-1:0] OP_LOAD  = OP_W'(6'b100011),
   parameter logic [OP_W-1:0] OP_STORE = OP_W'(6'b101011),
   parameter logic [OP_W-1:0] OP_RREG  = OP_W'(6'b000000),
   parameter logic [OP_W-1:0] OP_BEQ   = OP_W'(6'b000100),
   parameter logic [OP_W-1:0] OP_JUMP  = OP_W'(6'b000010)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [OP_W-1:0]    opcode,
   input logic [STATE_W-1:0] cur_state,
   input logic               pc_wr,
   input logic               pc_wr_cond,
   input logic               mem_rd,
   input logic               mem_wr,
   input logic               rf_wr
);
   localparam logic [STATE_W-1:0] S0 = STATE_W'(0);
   localparam logic [STATE_W-1:0] S1 = STATE_W'(1);
   localparam logic [STATE_W-1:0] S2 = STATE_W'(2);
   localparam logic [STATE_W-1:0] S3 = STATE_W'(3);
   localparam logic [STATE_W-1:0] S4 = STATE_W'(4);
   localparam logic [STATE_W-1:0] S5 = STATE_W'(5);
   localparam logic [STATE_W-1:0] S6 = STATE_W'(6);
   localparam logic [STATE_W-1:0] S7 = STATE_W'(7);
   localparam logic [STATE_W-1:0] S8 = STATE_W'(8);
   localparam logic [STATE_W-1:0] S9 = STATE_W'(9);

   logic known_op;
   assign known_op = (opcode == OP_LOAD) || (opcode == OP_STORE) || (opcode == OP_RREG) ||
                     (opcode == OP_BEQ) || (opcode == OP_JUMP);

   p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cur_state == S0 |=> cur_state == S1);

   p_mem_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == S1 && (opcode == OP_LOAD || opcode == OP_STORE)) |=> cur_state == S2);

   p_rreg_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == S1 && opcode == OP_RREG) |=> cur_state == S6);

   p_beq_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == S1 && opcode == OP_BEQ) |=> cur_state == S8);

   p_jump_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == S1 && opcode == OP_JUMP) |=> cur_state == S9);

   p_unknown_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == S1 && !known_op) |=> cur_state == S0);

   p_load_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == S2 && opcode == OP_LOAD) |=> cur_state == S3);

   p_store_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == S2 && opcode == OP_STORE) |=> cur_state == S5);

   p_read_to_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cur_state == S3 |=> cur_state == S4);

   p_exec_to_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cur_state == S6 |=> cur_state == S7);

   p_last_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == S4 || cur_state == S5 || cur_state == S7 || cur_state == S8 ||
       cur_state == S9) |=> cur_state == S0);

   p_pc_write_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr |-> (cur_state == S0 || cur_state == S9));

   p_pc_cond_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr_cond |-> cur_state == S8);

   p_reg_write_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr |-> (cur_state == S4 || cur_state == S7));

   p_mem_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_step_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cur_state <= S9);
endmodule

bind mcyc_ctrl_fsm mcyc_ctrl_fsm_chk #(
   .STATE_W(STATE_W), .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
   .OP_RREG(OP_RREG), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .opcode    (opcode),
   .cur_state (cur_state),
   .pc_wr     (pc_wr),
   .pc_wr_cond(pc_wr_cond),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .rf_wr     (rf_wr)
);

// File: tb/mcyc_ctrl_fsm_bench.sv
`timescale 1ns/1ps
module mcyc_ctrl_fsm_bench;
   localparam int HALF = 2;   // 250 MHz
   localparam logic [5:0] LD = 6'b100011, ST = 6'b101011, RR = 6'b000000,
                          BQ = 6'b000100, JP = 6'b000010;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] opcode = 6'd0;
   logic [3:0] cur_state;
   logic       pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_wr, rf_wb_sel;
   logic [1:0] pc_src_sel, alu_op, alu_b_sel;
   logic       alu_a_sel, rf_wr, rf_dst_sel;
   logic [15:0] act_word;

   int n_chk = 0;
   int n_err = 0;
   int exp_state = 0;
   bit done = 1'b0;

   always #HALF clk = ~clk;

   mcyc_ctrl_fsm u_mcyc_ctrl_fsm (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .cur_state(cur_state),
      .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_addr_sel(mem_addr_sel),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .rf_wb_sel(rf_wb_sel),
      .pc_src_sel(pc_src_sel), .alu_op(alu_op), .alu_b_sel(alu_b_sel),
      .alu_a_sel(alu_a_sel), .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel)
   );

   assign act_word = {pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_wr, rf_wb_sel,
                      pc_src_sel, alu_op, alu_b_sel, alu_a_sel, rf_wr, rf_dst_sel};

   // Expected word per step, field order as act_word (R10).
   function automatic logic [15:0] model_word(input int s);
      case (s)
         0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,2'b01,1'b0,1'b0,1'b0};
         1: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b11,1'b0,1'b0,1'b0};
         2: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b10,1'b1,1'b0,1'b0};
         3: return {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0};
         4: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,2'b00,1'b0,1'b1,1'b0};
         5: return {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0};
         6: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b10,2'b00,1'b1,1'b0,1'b0};
         7: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,1'b1};
         8: return {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,2'b00,1'b1,1'b0,1'b0};
         9: return {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,2'b00,2'b00,1'b0,1'b0,1'b0};
         default: return 16'h0;
      endcase
   endfunction

   function automatic int model_next(input int s, input logic [5:0] op);
      case (s)
         0: return 1;
         1: begin
            if (op == LD || op == ST) return 2;
            if (op == RR) return 6;
            if (op == BQ) return 8;
            if (op == JP) return 9;
            return 0;
         end
         2: return (op == LD) ? 3 : ((op == ST) ? 5 : 0);
         3: return 4;
         6: return 7;
         default: return 0;
      endcase
   endfunction

   function automatic int model_len(input logic [5:0] op);
      if (op == LD) return 5;
      if (op == ST || op == RR) return 4;
      if (op == BQ || op == JP) return 3;
      return 2;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h (step %0d)", req, act, exp, exp_state);
      end
   endtask

   task automatic cycle_checks(input string req);
      chk(req, 32'(cur_state), 32'(exp_state));
      chk("R10", 32'(act_word), 32'(model_word(exp_state)));
      chk("R7", 32'(pc_wr), 32'(exp_state == 0 || exp_state == 9));
      chk("R8", 32'(rf_wr), 32'(exp_state == 4 || exp_state == 7));
      chk("R9", 32'(mem_wr & mem_rd), 32'd0);
      chk("R11", 32'(cur_state <= 4'd9), 32'd1);
   endtask

   // One clock edge; the model follows the opcode present at that edge.
   task automatic step(output string req);
      int prev;
      @(posedge clk);
      prev = exp_state;
      exp_state = model_next(exp_state, opcode);
      #1;
      if (prev == 0)      req = "R2";
      else if (prev == 1) req = "R3";
      else if (prev == 2) req = "R4";
      else                req = "R5";
   endtask

   initial begin
      string rq;
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R1", 32'(cur_state), 32'd0);
      chk("R1", 32'(act_word), 32'(model_word(0)));
      rst_n = 1'b1;
      exp_state = 0;

      // Every opcode, one instruction each, with mid-cycle opcode wiggle (R6).
      for (int op = 0; op < 64; op++) begin
         int cyc;
         opcode = 6'(op);
         cyc = 0;
         do begin
            step(rq);
            cycle_checks(rq);
            opcode = ~6'(op);
            #1;
            chk("R6", 32'(act_word), 32'(model_word(exp_state)));
            chk("R6", 32'(cur_state), 32'(exp_state));
            opcode = 6'(op);
            cyc++;
         end while (exp_state != 0 && cyc < 8);
         chk("R5", 32'(cyc), 32'(model_len(6'(op))));
      end

      // R4: class changes to register-format while in step 2
      opcode = LD;
      step(rq); cycle_checks(rq);
      step(rq); cycle_checks(rq);
      chk("R3", 32'(cur_state), 32'd2);
      opcode = RR;
      step(rq); cycle_checks(rq);
      chk("R4", 32'(cur_state), 32'd0);

      // R4: store path reaches step 5
      opcode = ST;
      step(rq); step(rq); step(rq);
      cycle_checks(rq);
      chk("R4", 32'(cur_state), 32'd5);
      step(rq); cycle_checks(rq);

      // R1: asynchronous reset in the middle of a load
      opcode = LD;
      step(rq); step(rq); step(rq);
      chk("R4", 32'(cur_state), 32'd3);
      rst_n = 1'b0;
      #1;
      exp_state = 0;
      chk("R1", 32'(cur_state), 32'd0);
      chk("R1", 32'(act_word), 32'(model_word(0)));
      @(posedge clk);
      #1;
      chk("R1", 32'(cur_state), 32'd0);
      rst_n = 1'b1;
      step(rq); cycle_checks(rq);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(200000 * 2 * HALF);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule